// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block runs one short command against a serial flash device over a single data lane. Software writes one control word with the execute bit set. The block then sends an opcode, followed by an optional address, an optional run of dummy clocks, and up to eight bytes of outgoing data, incoming data, or both. Chip select stays low for the whole command. A busy flag tells software when the command has finished and the returned bytes can be read.

The control word holds the phase enables and the byte counts. Each byte count is stored as the number of bytes minus one. The address word and the two outgoing data words are copied into the block when a command is accepted. Returned bytes are packed little-endian into two 32-bit words. The serial clock runs at the system clock divided by twice `HALF_DIV`. It uses mode 0: the clock idles low, data is sampled on the rising edge and changed on the falling edge, and each byte goes out most-significant bit first.

Top module: `flash_cmd_engine`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, busy is low and both read-data words are zero.
- R2: A control-word write with bit 0 set is accepted only while idle, and busy reads 1 from the next cycle until the command ends. A write without bit 0 starts nothing. An execute request while busy is ignored and does not change the frame in progress.
- R3: The opcode in control bits 31:24 is the first byte on the data-out line, sent MSB first. The serial clock idles low, and data-out is stable at every rising edge.
- R4: When control bit 19 is set, an address phase follows the opcode. It carries (bits 17:16)+1 bytes: the low-order bytes of the address word, highest of them first.
- R5: Control bits 11:7 give a count of 0 to 31 dummy clocks. These come after the address and drive data-out low.
- R6: When control bit 15 is set, (bits 14:12)+1 write bytes follow the dummy clocks. Byte k is taken from bits 8k+7:8k of {upper word, lower word}.
- R7: When control bit 23 is set, (bits 22:20)+1 bytes are read while data-out is held low. Received byte k is stored in bits 8k+7:8k of {upper word, lower word}. Bits are taken from data-in on rising edges, MSB first.
- R8: Read-data byte positions that the command does not fill read as zero. This includes all eight bytes after a command with no read phase.
- R9: Chip select stays low from the opcode to the last bit, and goes high in the same cycle that busy falls. The serial clock never goes high while chip select is high.
- R10: When both data phases are enabled, all write bytes are sent before the first read byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdWe | input | 1 | Control-word write strobe |
| cmdWord | input | 32 | Control word (opcode, enables, counts, execute bit 0) |
| addrWord | input | 32 | Address for the address phase |
| wrDataLo | input | 32 | Write bytes 0 to 3 |
| wrDataHi | input | 32 | Write bytes 4 to 7 |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| busy | output | 1 | Command in progress |
| rdDataLo | output | 32 | Read bytes 0 to 3 |
| rdDataHi | output | 32 | Read bytes 4 to 7 |

## Verification
Fixed commands cover the edge cases: opcode only, a one-byte and a four-byte address, the full 31 dummy clocks, a short identify-style read that leaves upper bytes zero, and a write-then-read that shows the phase order. Random control words then vary every enable, count and dummy length together. These separate faults in phase sequencing from faults in byte selection and packing. A slave model records every bit on data-out and drives a data-in pattern that depends on bit position, so a read byte taken one bit early or late gives a different value. One run sends an execute request while busy and a control write without the execute bit. Both must leave the frame count and the bit stream unchanged.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int OPC_LSB     = 24;
  localparam int RD_EN_BIT   = 23;
  localparam int RD_CNT_LSB  = 20;
  localparam int ADDR_EN_BIT = 19;
  localparam int ADDR_CNT_LSB = 16;
  localparam int WR_EN_BIT   = 15;
  localparam int WR_CNT_LSB  = 12;
  localparam int DUMMY_LSB   = 7;
  localparam int EXEC_BIT    = 0;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_OPC   = 3'd1,
    PH_ADDR  = 3'd2,
    PH_DUMMY = 3'd3,
    PH_WDATA = 3'd4,
    PH_RDATA = 3'd5
  } phase_t;

  typedef struct packed {
    logic       load;
    logic [7:0] loadData;
    logic [3:0] loadBits;
    logic       csOn;
    logic       csOff;
    logic       rdClear;
    logic       rdStore;
    logic [2:0] rdIdx;
  } strobe_t;
endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWe,
  input  logic [31:0] cmdWord,
  input  logic [31:0] addrWord,
  input  logic [31:0] wrLo,
  input  logic [31:0] wrHi,
  input  logic        unitDone,
  output strobe_t     strb,
  output logic        busy
);
  phase_t      phase, nxtPhase;
  logic [2:0]  idx, nxtIdx;
  logic [4:0]  dummyLeft, dumRem;
  logic [3:0]  dumBits;
  logic        addrEnQ, wrEnQ, rdEnQ;
  logic [1:0]  addrCntQ;
  logic [2:0]  wrCntQ, rdCntQ;
  logic [4:0]  dummyQ;
  logic [31:0] addrQ, addrShifted;
  logic [63:0] wrBufQ;
  logic [5:0]  enVec;
  logic        accept, stay;

  function automatic phase_t firstAfter(phase_t cur, logic [5:0] en);
    phase_t r;
    r = PH_IDLE;
    for (int p = 5; p >= 1; p--)
      if (p > int'(cur) && en[p]) r = phase_t'(3'(p));
    return r;
  endfunction

  assign busy   = (phase != PH_IDLE);
  assign accept = !busy && cmdWe && cmdWord[EXEC_BIT];
  assign enVec  = {rdEnQ, wrEnQ, (dummyQ != 5'd0), addrEnQ, 2'b00};

  always_comb begin
    strb        = '0;
    nxtPhase    = phase;
    nxtIdx      = idx;
    stay        = 1'b0;
    dumRem      = (phase == PH_DUMMY) ? dummyLeft : dummyQ;
    dumBits     = (dumRem > 5'd8) ? 4'd8 : dumRem[3:0];
    addrShifted = '0;
    if (accept) begin
      nxtPhase      = PH_OPC;
      nxtIdx        = '0;
      strb.csOn     = 1'b1;
      strb.rdClear  = 1'b1;
      strb.load     = 1'b1;
      strb.loadData = cmdWord[OPC_LSB +: 8];
      strb.loadBits = 4'd8;
    end else if (busy && unitDone) begin
      if (phase == PH_RDATA) begin
        strb.rdStore = 1'b1;
        strb.rdIdx   = idx;
      end
      stay = (phase == PH_ADDR  && idx != {1'b0, addrCntQ}) ||
             (phase == PH_DUMMY && dummyLeft != 5'd0) ||
             (phase == PH_WDATA && idx != wrCntQ) ||
             (phase == PH_RDATA && idx != rdCntQ);
      if (stay) nxtIdx = idx + 3'd1;
      else begin
        nxtPhase = firstAfter(phase, enVec);
        nxtIdx   = '0;
      end
      addrShifted = addrQ >> {addrCntQ - nxtIdx[1:0], 3'b000};
      if (nxtPhase == PH_IDLE) strb.csOff = 1'b1;
      else begin
        strb.load     = 1'b1;
        strb.loadBits = 4'd8;
        case (nxtPhase)
          PH_ADDR:  strb.loadData = addrShifted[7:0];
          PH_DUMMY: strb.loadBits = dumBits;
          PH_WDATA: strb.loadData = wrBufQ[{nxtIdx, 3'b000} +: 8];
          default:  strb.loadData = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;  idx <= '0;  dummyLeft <= '0;
      addrEnQ <= 1'b0;  wrEnQ <= 1'b0;  rdEnQ <= 1'b0;
      addrCntQ <= '0;  wrCntQ <= '0;  rdCntQ <= '0;  dummyQ <= '0;
      addrQ <= '0;  wrBufQ <= '0;
    end else begin
      phase <= nxtPhase;
      idx   <= nxtIdx;
      if (accept) begin
        addrEnQ  <= cmdWord[ADDR_EN_BIT];
        addrCntQ <= cmdWord[ADDR_CNT_LSB +: 2];
        wrEnQ    <= cmdWord[WR_EN_BIT];
        wrCntQ   <= cmdWord[WR_CNT_LSB +: 3];
        rdEnQ    <= cmdWord[RD_EN_BIT];
        rdCntQ   <= cmdWord[RD_CNT_LSB +: 3];
        dummyQ   <= cmdWord[DUMMY_LSB +: 5];
        addrQ    <= addrWord;
        wrBufQ   <= {wrHi, wrLo};
      end
      if (strb.load && nxtPhase == PH_DUMMY)
        dummyLeft <= dumRem - {1'b0, dumBits};
    end
  end

  // R2: an accepted execute makes the block busy on the next cycle
  p_exec_starts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdWe && cmdWord[EXEC_BIT]) |=> busy);
  // R2: while busy, sequencing moves only on unit completion, whatever cmdWe does
  p_busy_ignores_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !unitDone) |=> ($stable(phase) && $stable(idx)));
endmodule

// File: rtl/flash_cmd_datapath.sv
module flash_cmd_datapath
  import flash_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     strb,
  input  logic        miso,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  output logic        unitDone,
  output logic [31:0] rdLo,
  output logic [31:0] rdHi
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] halfCnt;
  logic [7:0]    txShift, rxShift;
  logic [3:0]    bitsLeft;
  logic          active, tick;
  logic [63:0]   rdBuf;

  assign tick = active && (halfCnt == CW'(HALF_DIV - 1));
  assign mosi = active & txShift[7];
  assign rdLo = rdBuf[31:0];
  assign rdHi = rdBuf[63:32];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN <= 1'b1;  sclk <= 1'b0;  active <= 1'b0;  unitDone <= 1'b0;
      halfCnt <= '0;  txShift <= '0;  rxShift <= '0;  bitsLeft <= '0;
      rdBuf <= '0;
    end else begin
      unitDone <= 1'b0;
      if (strb.csOn)  csN <= 1'b0;
      if (strb.csOff) csN <= 1'b1;
      if (strb.load) begin
        active   <= 1'b1;
        txShift  <= strb.loadData;
        bitsLeft <= strb.loadBits;
        halfCnt  <= '0;
        sclk     <= 1'b0;
      end else if (active) begin
        halfCnt <= tick ? '0 : halfCnt + CW'(1);
        if (tick) begin
          if (!sclk) begin
            sclk    <= 1'b1;
            rxShift <= {rxShift[6:0], miso};
          end else begin
            sclk <= 1'b0;
            if (bitsLeft == 4'd1) begin
              active   <= 1'b0;
              unitDone <= 1'b1;
            end else begin
              bitsLeft <= bitsLeft - 4'd1;
              txShift  <= {txShift[6:0], 1'b0};
            end
          end
        end
      end
      if (strb.rdClear) rdBuf <= '0;
      else if (strb.rdStore) rdBuf[{strb.rdIdx, 3'b000} +: 8] <= rxShift;
    end
  end

  // R9: control never starts a new unit while one is shifting
  p_load_when_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> !active);
  // R9: serial clock stays low whenever chip select is released
  p_sclk_needs_cs_r9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);
  // R8: a new command starts with an empty read buffer
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdClear |=> (rdBuf == 64'd0));
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import flash_cmd_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWe,
  input  logic [31:0] cmdWord,
  input  logic [31:0] addrWord,
  input  logic [31:0] wrDataLo,
  input  logic [31:0] wrDataHi,
  input  logic        miso,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  output logic        busy,
  output logic [31:0] rdDataLo,
  output logic [31:0] rdDataHi
);
  strobe_t strb;
  logic    unitDone;

  flash_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWord(cmdWord),
    .addrWord(addrWord), .wrLo(wrDataLo), .wrHi(wrDataHi),
    .unitDone(unitDone), .strb(strb), .busy(busy)
  );

  flash_cmd_datapath #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .miso(miso),
    .csN(csN), .sclk(sclk), .mosi(mosi), .unitDone(unitDone),
    .rdLo(rdDataLo), .rdHi(rdDataHi)
  );

  // R9: chip select is high whenever the block is idle
  p_idle_cs_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);
  // R9: chip select rises together with the end of busy
  p_cs_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> csN);
endmodule

// File: tb/flash_cmd_engine_tb.sv
module flash_cmd_engine_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, cmdWe, miso;
  logic [31:0] cmdWord, addrWord, wrDataLo, wrDataHi;
  logic        csN, sclk, mosi, busy;
  logic [31:0] rdDataLo, rdDataHi;

  flash_cmd_engine u_dut (
    .clk(clk), .rstN(rstN), .cmdWe(cmdWe), .cmdWord(cmdWord),
    .addrWord(addrWord), .wrDataLo(wrDataLo), .wrDataHi(wrDataHi),
    .miso(miso), .csN(csN), .sclk(sclk), .mosi(mosi), .busy(busy),
    .rdDataLo(rdDataLo), .rdDataHi(rdDataHi)
  );

  int tests = 0, fails = 0;
  int frames = 0, capN = 0, csViol = 0;
  bit capBits [256];
  bit expBits [256];
  int expN;
  logic [31:0] slvSeed = 32'd0;

  function automatic bit respBit(logic [31:0] s, int i);
    logic [31:0] h;
    h = (32'(i) ^ s) * 32'h045D9F3B;
    return h[17];
  endfunction

  function automatic logic [31:0] mk(logic [7:0] op, bit aEn, logic [1:0] aCnt,
      logic [4:0] dum, bit wEn, logic [2:0] wCnt, bit rEn, logic [2:0] rCnt);
    return {op, rEn, rCnt, aEn, 1'b0, aCnt, wEn, wCnt, dum, 6'b0, 1'b1};
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  // slave model: capture data-out on rising edges, drive data-in after falling edges
  initial begin
    miso = 1'b0;
    forever begin
      @(negedge csN);
      frames++;
      capN = 0;
      miso = respBit(slvSeed, 0);
      while (csN == 1'b0) begin
        @(posedge sclk or posedge csN);
        if (csN) break;
        if (capN < 256) capBits[capN] = mosi;
        capN++;
        @(negedge sclk or posedge csN);
        if (!csN) miso = respBit(slvSeed, capN);
      end
    end
  end

  always @(negedge clk) if (rstN === 1'b1 && csN === 1'b1 && sclk === 1'b1) csViol++;

  task automatic pushByte(logic [7:0] b);
    for (int j = 7; j >= 0; j--) begin expBits[expN] = b[j]; expN++; end
  endtask

  task automatic runCmd(logic [31:0] ctrl, logic [31:0] addr, logic [31:0] lo,
                        logic [31:0] hi, logic [31:0] seed, logic [31:0] intruder);
    int f0, guard, rs, bad, rn;
    logic [63:0] expRd, wb;
    slvSeed = seed;
    f0 = frames;
    @(negedge clk);
    cmdWord = ctrl; addrWord = addr; wrDataLo = lo; wrDataHi = hi; cmdWe = 1'b1;
    @(negedge clk);
    cmdWe = 1'b0;
    chk("R2 busy after execute", {63'd0, busy}, 64'd1);
    if (intruder != 0) begin
      repeat (6) @(negedge clk);
      cmdWord = intruder; addrWord = ~addr; wrDataLo = ~lo; wrDataHi = ~hi; cmdWe = 1'b1;
      @(negedge clk);
      cmdWe = 1'b0; cmdWord = ctrl; addrWord = addr; wrDataLo = lo; wrDataHi = hi;
    end
    guard = 0;
    while (busy && guard < 5000) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
    // expected bit stream
    expN = 0;
    pushByte(ctrl[31:24]);
    if (ctrl[19])
      for (int b = int'(ctrl[17:16]); b >= 0; b--) pushByte(addr[8*b +: 8]);
    for (int d = 0; d < int'(ctrl[11:7]); d++) begin expBits[expN] = 1'b0; expN++; end
    wb = {hi, lo};
    if (ctrl[15])
      for (int k = 0; k <= int'(ctrl[14:12]); k++) pushByte(wb[8*k +: 8]);
    rs = expN;
    expRd = '0;
    rn = ctrl[23] ? int'(ctrl[22:20]) + 1 : 0;
    for (int k = 0; k < rn; k++) begin
      pushByte(8'h00);
      for (int j = 0; j < 8; j++) expRd[8*k + 7 - j] = respBit(seed, rs + 8*k + j);
    end
    chk("R2 one frame per accepted execute", 64'(frames - f0), 64'd1);
    chk("R3 R4 R5 R6 R7 R10 bit count", 64'(capN), 64'(expN));
    bad = 0;
    for (int i = 0; i < expN && i < 256; i++) if (capBits[i] != expBits[i]) bad++;
    chk("R3 R4 R5 R6 R10 stream mismatches", 64'(bad), 64'd0);
    chk("R7 R8 read data lower", {32'd0, rdDataLo}, {32'd0, expRd[31:0]});
    chk("R7 R8 read data upper", {32'd0, rdDataHi}, {32'd0, expRd[63:32]});
    chk("R9 chip select released", {63'd0, csN}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired got running exp finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int f0;
    void'($urandom(32'd2024));
    rstN = 1'b0; cmdWe = 1'b0; cmdWord = '0; addrWord = '0; wrDataLo = '0; wrDataHi = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset csN", {63'd0, csN}, 64'd1);
    chk("R1 reset sclk", {63'd0, sclk}, 64'd0);
    chk("R1 reset busy", {63'd0, busy}, 64'd0);
    chk("R1 reset read words", {rdDataHi, rdDataLo}, 64'd0);

    // R2: write without execute bit starts nothing
    f0 = frames;
    cmdWord = mk(8'h06, 0, 0, 0, 0, 0, 0, 0) & ~32'd1; cmdWe = 1'b1;
    @(negedge clk); cmdWe = 1'b0;
    repeat (20) @(negedge clk);
    chk("R2 no start without execute bit", {63'd0, busy}, 64'd0);
    chk("R2 no frame without execute bit", 64'(frames - f0), 64'd0);

    // R3: opcode only
    runCmd(mk(8'hA5, 0, 0, 0, 0, 0, 0, 0), 0, 0, 0, 32'h11, 0);
    // R7 R8: identify-style read of three bytes
    runCmd(mk(8'h9F, 0, 0, 0, 0, 0, 1, 3'd2), 0, 0, 0, 32'h1234, 0);
    // R4 R5 R7: four-byte address, eight dummy clocks, eight read bytes
    runCmd(mk(8'h0C, 1, 2'd3, 5'd8, 0, 0, 1, 3'd7), 32'hC3A5_5A3C, 0, 0, 32'h77, 0);
    // R4 R6: three-byte address then eight write bytes, read words zero (R8)
    runCmd(mk(8'h02, 1, 2'd2, 0, 1, 3'd7, 0, 0), 32'hFF12_3456, 32'h4433_2211,
           32'h8877_6655, 32'h5, 0);
    // R5: maximum dummy length, odd count, one-byte address
    runCmd(mk(8'h0B, 1, 2'd0, 5'd31, 0, 0, 1, 3'd0), 32'h0000_00E7, 0, 0, 32'h99, 0);
    // R10: write five bytes then read two
    runCmd(mk(8'h4B, 0, 0, 5'd3, 1, 3'd4, 1, 3'd1), 0, 32'hDEAD_BEEF, 32'h0000_00C1,
           32'hABC, 0);
    // R2: execute request while busy is ignored
    runCmd(mk(8'h3B, 1, 2'd2, 5'd4, 0, 0, 1, 3'd5), 32'h0012_3456, 0, 0, 32'h42,
           mk(8'hC7, 0, 0, 0, 0, 0, 0, 0));

    for (int n = 0; n < 40; n++) begin
      logic [31:0] r;
      r = $urandom;
      runCmd(mk(8'($urandom), r[0], r[2:1], r[7:3], r[8], r[11:9], r[12], r[15:13]),
             $urandom, $urandom, $urandom, $urandom, 0);
    end

    chk("R9 sclk never high with chip select released", 64'(csViol), 64'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule